// File: doc/BRIEF.md
# Timer Capture/Compare Channel

This channel sits beside a free-running timer and shares a single register between two jobs, chosen by a 4-bit mode input. In the capture modes it watches an asynchronous input pin and, on the selected edge (or on every 4th or 16th rising edge), stores the current timer value in the register. In the compare modes the register holds a target value. When the timer reaches that target, the channel sets its output pin, clears it, raises only the flag, or emits a one-cycle trigger pulse that a timer can take as a synchronous reset request.

Every capture and every compare match sets a sticky interrupt flag, and a clear strobe lowers it. Software loads the register through a plain write strobe. All outputs are registered. The block has no streaming data path, so all pins are plain control and status signals with no valid/ready handshake and no back-pressure.

Top module: `capcmp_unit`

## Requirements
- R1: While rst_n is low, val_o, pin_o, trig_o and irq_o are all 0, and the stored mode is taken as 0000.
- R2: pin_i is passed through two synchronizing flops before edge detection. A capture loads the timer_i value present in the cycle that ends at the third rising clock edge after the pin changes, and val_o shows it after that edge.
- R3: Mode 0100 captures on every falling edge of pin_i, and mode 0101 captures on every rising edge.
- R4: Mode 0110 captures on every 4th rising edge and mode 0111 on every 16th. The edge counter returns to zero after each capture and on every mode change.
- R5: On entry to mode 1000, pin_o goes to 0 and a compare match then drives it to 1. On entry to mode 1001, pin_o goes to 1 and a match then drives it to 0.
- R6: A compare match needs timer_i to equal the register in a cycle where timer_i differs from its value in the previous cycle. A timer that holds its value therefore matches at most once.
- R7: In mode 1011 a match produces a one-cycle pulse on trig_o. In mode 1010 a match sets only the flag. Neither mode changes pin_o.
- R8: irq_o is set after each capture and each compare match, and cleared by irq_clr_i. A set and a clear in the same cycle leave irq_o at 1.
- R9: val_we_i loads val_wdata_i into the register in any mode. A capture in the same cycle takes priority over the write.
- R10: Modes 0000, 0001, 001x and 11xx never capture and never match, and pin_o holds its value in them.
- R11: In the cycle in which mode_i differs from the previous cycle's mode, no capture and no match take place.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_i | input | 4 | Mode select |
| timer_i | input | 16 | Free-running timer value |
| pin_i | input | 1 | Asynchronous capture input pin |
| val_we_i | input | 1 | Register write strobe |
| val_wdata_i | input | 16 | Register write data |
| irq_clr_i | input | 1 | Interrupt flag clear strobe |
| val_o | output | 16 | Capture/compare register contents |
| pin_o | output | 1 | Output pin drive level |
| trig_o | output | 1 | Special-event trigger pulse |
| irq_o | output | 1 | Sticky interrupt flag |

## Verification
Two pairs of functions can land in the same cycle. A detected capture can coincide with a register write, and a flag set from a capture or match can coincide with a flag clear. Random write and clear strobes run alongside a randomly toggling pin and a timer that sometimes holds, so both collisions happen often in every capture and compare mode. A behavioural model applies capture-over-write and set-over-clear priority and is compared with the outputs on every cycle.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam logic [3:0] CM_OFF      = 4'b0000;
  localparam logic [3:0] CM_CAP_FALL = 4'b0100;
  localparam logic [3:0] CM_CAP_RISE = 4'b0101;
  localparam logic [3:0] CM_CAP_R4   = 4'b0110;
  localparam logic [3:0] CM_CAP_R16  = 4'b0111;
  localparam logic [3:0] CM_CMP_SET  = 4'b1000;
  localparam logic [3:0] CM_CMP_CLR  = 4'b1001;
  localparam logic [3:0] CM_CMP_FLAG = 4'b1010;
  localparam logic [3:0] CM_CMP_TRIG = 4'b1011;

  function automatic logic is_compare(input logic [3:0] m);
    return m[3:2] == 2'b10;
  endfunction
endpackage

// File: rtl/capcmp_edge.sv
module capcmp_edge
  import capcmp_pkg::*;
#(
  parameter int DIV_A = 4,
  parameter int DIV_B = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pin_i,
  input  logic [3:0] mode_i,
  input  logic       mode_chg_i,
  output logic       cap_ev_o
);
  localparam int CW = $clog2(DIV_B + 1);

  logic [2:0]    sh_q;
  logic [CW-1:0] cnt_q, cnt_d, lim;
  logic          rise, fall;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[1:0], pin_i};

  assign rise = sh_q[1] & ~sh_q[2];
  assign fall = ~sh_q[1] & sh_q[2];
  assign lim  = (mode_i == CM_CAP_R16) ? CW'(DIV_B - 1) : CW'(DIV_A - 1);

  always_comb begin
    cap_ev_o = 1'b0;
    cnt_d    = cnt_q;
    if (mode_chg_i) cnt_d = '0;
    else begin
      case (mode_i)
        CM_CAP_FALL: cap_ev_o = fall;
        CM_CAP_RISE: cap_ev_o = rise;
        CM_CAP_R4, CM_CAP_R16:
          if (rise) begin
            if (cnt_q == lim) begin
              cap_ev_o = 1'b1;
              cnt_d    = '0;
            end else cnt_d = cnt_q + 1'b1;
          end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;

  // R4
  div4_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == CM_CAP_R4 && !mode_chg_i) |-> (cnt_q < CW'(DIV_A)));
endmodule

// File: rtl/capcmp_match.sv
module capcmp_match #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en_i,
  input  logic [TW-1:0] timer_i,
  input  logic [TW-1:0] ref_i,
  output logic          hit_o
);
  logic [TW-1:0] tprev_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) tprev_q <= '0;
    else        tprev_q <= timer_i;

  assign hit_o = en_i && (timer_i == ref_i) && (timer_i != tprev_q);

  // R6
  hold_nohit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !(hit_o && $stable(timer_i)));
endmodule

// File: rtl/capcmp_unit.sv
module capcmp_unit
  import capcmp_pkg::*;
#(
  parameter int TW    = 16,
  parameter int DIV_A = 4,
  parameter int DIV_B = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [3:0]    mode_i,
  input  logic [TW-1:0] timer_i,
  input  logic          pin_i,
  input  logic          val_we_i,
  input  logic [TW-1:0] val_wdata_i,
  input  logic          irq_clr_i,
  output logic [TW-1:0] val_o,
  output logic          pin_o,
  output logic          trig_o,
  output logic          irq_o
);
  logic [3:0] mode_q;
  logic       mode_chg, cap_ev, hit;

  assign mode_chg = (mode_i != mode_q);

  capcmp_edge #(.DIV_A(DIV_A), .DIV_B(DIV_B)) u_edge (
    .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .mode_i(mode_i),
    .mode_chg_i(mode_chg), .cap_ev_o(cap_ev)
  );

  capcmp_match #(.TW(TW)) u_match (
    .clk(clk), .rst_n(rst_n), .en_i(!mode_chg && is_compare(mode_i)),
    .timer_i(timer_i), .ref_i(val_o), .hit_o(hit)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode_q <= CM_OFF;
      val_o  <= '0;
      pin_o  <= 1'b0;
      trig_o <= 1'b0;
      irq_o  <= 1'b0;
    end else begin
      mode_q <= mode_i;
      if (cap_ev)        val_o <= timer_i;
      else if (val_we_i) val_o <= val_wdata_i;
      if (mode_chg) begin
        if (mode_i == CM_CMP_SET)      pin_o <= 1'b0;
        else if (mode_i == CM_CMP_CLR) pin_o <= 1'b1;
      end else if (hit) begin
        if (mode_i == CM_CMP_SET)      pin_o <= 1'b1;
        else if (mode_i == CM_CMP_CLR) pin_o <= 1'b0;
      end
      trig_o <= hit && (mode_i == CM_CMP_TRIG);
      if (cap_ev || hit)  irq_o <= 1'b1;
      else if (irq_clr_i) irq_o <= 1'b0;
    end

  // R2
  cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cap_ev |=> (val_o == $past(timer_i)));
  // R7
  trig_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trig_o |-> irq_o);
  // R8
  flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(cap_ev || hit));
  // R10
  pin_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_chg && !is_compare(mode_i)) |=> $stable(pin_o));
endmodule

// File: tb/capcmp_unit_test.sv
module capcmp_unit_test;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  mode_i = 0;
  logic [15:0] timer_i = 16'hFFE0, val_wdata_i = 0;
  logic        pin_i = 0, val_we_i = 0, irq_clr_i = 0;
  logic [15:0] val_o;
  logic        pin_o, trig_o, irq_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  capcmp_unit uut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .timer_i(timer_i), .pin_i(pin_i),
    .val_we_i(val_we_i), .val_wdata_i(val_wdata_i), .irq_clr_i(irq_clr_i),
    .val_o(val_o), .pin_o(pin_o), .trig_o(trig_o), .irq_o(irq_o)
  );

  always #4 clk = ~clk;

  // reference model state (after each rising edge)
  bit s1, s2, s3, m_pin, m_trig, m_irq;
  int m_mode, m_cnt, m_val, m_tprev;

  task automatic chk(input string tag, input int act, input int exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step();
    bit rise, fall, chg, cap, hit;
    int md, lim;
    md   = int'(mode_i);
    rise = s2 && !s3;
    fall = !s2 && s3;
    chg  = (md != m_mode);       // R11
    cap  = 0;
    if (chg) m_cnt = 0;          // R4 counter cleared on mode change
    else if (md == 4) cap = fall; // R3
    else if (md == 5) cap = rise;
    else if ((md == 6 || md == 7) && rise) begin
      lim = (md == 6) ? 4 : 16;
      if (m_cnt == lim - 1) begin cap = 1; m_cnt = 0; end
      else m_cnt++;
    end
    // R6 R10: match only in 10xx and only when the timer moved
    hit = !chg && (md >= 8 && md <= 11) && (int'(timer_i) == m_val) &&
          (int'(timer_i) != m_tprev);
    // R5
    if (chg) begin
      if (md == 8) m_pin = 0;
      else if (md == 9) m_pin = 1;
    end else if (hit) begin
      if (md == 8) m_pin = 1;
      else if (md == 9) m_pin = 0;
    end
    m_trig = hit && (md == 11);  // R7
    if (cap || hit) m_irq = 1;   // R8
    else if (irq_clr_i) m_irq = 0;
    if (cap) m_val = int'(timer_i); // R9 capture beats write
    else if (val_we_i) m_val = int'(val_wdata_i);
    s3 = s2; s2 = s1; s1 = pin_i; // R2 two-flop sync then edge
    m_tprev = int'(timer_i);
    m_mode  = md;
  endtask

  task automatic compare_all();
    chk("R2 R3 R4 R9 register", int'(val_o), m_val);
    chk("R5 R10 pin", int'(pin_o), int'(m_pin));
    chk("R7 trigger", int'(trig_o), int'(m_trig));
    chk("R8 flag", int'(irq_o), int'(m_irq));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int modes [18] = '{0, 4, 5, 6, 7, 8, 9, 10, 11, 1, 2, 3, 12, 15, 6, 7, 9, 8};
    logic [15:0] lf;
    lf = 16'hACE1;
    m_mode = 0; m_cnt = 0; m_val = 0; m_tprev = 0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset register", int'(val_o), 0);
    chk("R1 reset pin", int'(pin_o), 0);
    chk("R1 reset trigger", int'(trig_o), 0);
    chk("R1 reset flag", int'(irq_o), 0);
    rst_n = 1;
    model_step();
    @(negedge clk);
    compare_all();
    for (int ph = 0; ph < 18; ph++) begin
      for (int c = 0; c < 300; c++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        mode_i = 4'(modes[ph]);
        if (lf[0] && lf[1]) pin_i = ~pin_i;
        if (lf[2]) timer_i = timer_i + 16'd1;
        val_we_i    = (lf[5:3] == 3'd0);
        val_wdata_i = timer_i + 16'(lf[8:6]) + 16'd1;
        irq_clr_i   = (lf[11:9] == 3'd0) || (lf[11:9] == 3'd5);
        model_step();
        @(negedge clk);
        compare_all();
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule